// File: doc/BRIEF.md
# Flash Line Prefetch Buffer

This block sits between a 32-bit instruction fetch port and a flash array. The array is 128 bits wide. The array takes a programmable number of wait cycles to answer, and that number rises as the clock gets faster, because the access time of the array stays the same. The block reads a whole line of four words in one array access. It keeps two lines: the current line and the next line, which it reads ahead. A fetch that finds its word in one of the two lines gets the word in the same cycle. Code that runs straight through memory therefore sees no wait states, although every array access still takes its full latency.

A fetch that finds its word in neither line stalls the port and starts a demand read. While the processor takes words from the current line, the read engine fetches the following line into the second slot. When the fetch stream moves on, the read-ahead line becomes the current one, and a new read-ahead begins at once. A jump to a line that is in neither slot drops any read-ahead still in flight. Pulsing the invalidate input empties both slots after the array contents change.

Top module: `flash_line_prefetch`

## Requirements
- R1: While reset is asserted, and after reset while no fetch is requested, `fetch_ready` and `arr_en` are low.
- R2: A fetch whose line address (`fetch_addr[31:4]`) matches a valid held line raises `fetch_ready` in the same cycle. `fetch_rdata` then holds the word selected by `fetch_addr[3:2]`. Word k of a line occupies `arr_rdata[32k+31:32k]`.
- R3: A fetch that matches neither held line, with no read of its line in flight, holds `fetch_ready` low for exactly `wait_cfg`+1 cycles. The array read uses the value of `wait_cfg` at the start of the read. In the first of those cycles, `arr_en` is high and `arr_addr` equals the fetch's line address. The word is delivered in the next cycle.
- R4: Once a current line is valid, with no line held ahead and no read in progress, the block reads the following line (`arr_addr` = current line + 1). It does so without any miss.
- R5: A sequential fetch stream, one fetch per cycle, has no stall cycles after its first miss, for any `wait_cfg` from 0 to 3.
- R6: A fetch of the current line's last word while the ahead line is valid promotes the ahead line to current. A fetch served from the ahead line also promotes it. In the same cycle a read of the line after the promoted one starts.
- R7: A miss on a line other than the one being read ahead cancels that read. A demand read of the new line starts in the same cycle, so the stall is `wait_cfg`+1 cycles.
- R8: A miss on the line whose read is already in flight does not restart the read. The fetch waits only for the remaining cycles of that read.
- R9: Held lines keep their contents until invalidated. In a cycle with `inval` high, `fetch_ready` and `arr_en` are low. In the next cycle both slots are empty, so the next fetch misses and returns the array's new contents.
- R10: `fetch_rdata` is zero in every cycle that `fetch_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Fetch request valid |
| fetch_addr | input | 32 | Fetch byte address |
| wait_cfg | input | 3 | Array wait cycles per read |
| inval | input | 1 | Empty both held lines and drop any read in flight |
| fetch_ready | output | 1 | Fetch word delivered this cycle |
| fetch_rdata | output | 32 | Fetched word |
| arr_en | output | 1 | Array read active |
| arr_addr | output | 28 | Array line address |
| arr_rdata | input | 128 | Array line data, valid while the read is held |

## Verification
The bound checker checks the following on every cycle:
- a held miss always drives the array;
- a ready word is always backed by a live request and never coincides with an invalidate;
- the cycle after an invalidate never delivers a word;
- data is quiet whenever the port stalls;
- a held stall stays within a fixed bound.

Only the bench scenarios can show the following, because they depend on exact cycle counts and on the order of fetches:
- the exact stall length for each wait setting;
- zero-wait streaming across line boundaries;
- that a read-ahead is cancelled, or waited for, as the target address requires;
- that stale contents survive until an invalidate.

// File: rtl/flp_pkg.sv
package flp_pkg;
  typedef enum logic {
    RD_DEMAND = 1'b0,
    RD_AHEAD  = 1'b1
  } rd_kind_e;
endpackage

// File: rtl/flp_line_store.sv
module flp_line_store
  import flp_pkg::*;
#(
  parameter int TAG_W  = 28,
  parameter int WORD_W = 32,
  parameter int WPL    = 4,
  localparam int SEL_W  = $clog2(WPL),
  localparam int LINE_W = WORD_W * WPL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [TAG_W-1:0]  fetch_tag,
  input  logic [SEL_W-1:0]  fetch_sel,
  input  logic              promote,
  input  logic              fill_en,
  input  rd_kind_e          fill_kind,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_line,
  output logic              hit_cur,
  output logic              hit_nxt,
  output logic [WORD_W-1:0] sel_word,
  output logic [TAG_W-1:0]  cur_tag_o,
  output logic              cur_v_o,
  output logic [TAG_W-1:0]  nxt_tag_o,
  output logic              nxt_v_o
);
  logic              cur_v, cur_v_n, nxt_v, nxt_v_n;
  logic [TAG_W-1:0]  cur_tag, cur_tag_n, nxt_tag, nxt_tag_n;
  logic [LINE_W-1:0] cur_line, cur_line_n, nxt_line, nxt_line_n;
  logic              cur_ld, nxt_ld;
  logic [WORD_W-1:0] cur_w [WPL];
  logic [WORD_W-1:0] nxt_w [WPL];

  // Split each line into words; word k is the k-th slice from the bottom.
  for (genvar g = 0; g < WPL; g++) begin : g_word
    assign cur_w[g] = cur_line[g*WORD_W +: WORD_W];
    assign nxt_w[g] = nxt_line[g*WORD_W +: WORD_W];
  end

  assign hit_cur  = cur_v & (fetch_tag == cur_tag);
  assign hit_nxt  = nxt_v & (fetch_tag == nxt_tag);
  assign sel_word = hit_cur ? cur_w[fetch_sel] :
                    hit_nxt ? nxt_w[fetch_sel] : '0;

  assign cur_tag_o = cur_tag;
  assign cur_v_o   = cur_v;
  assign nxt_tag_o = nxt_tag;
  assign nxt_v_o   = nxt_v;

  always_comb begin
    cur_v_n    = cur_v;
    cur_tag_n  = cur_tag;
    cur_line_n = cur_line;
    nxt_v_n    = nxt_v;
    nxt_tag_n  = nxt_tag;
    nxt_line_n = nxt_line;
    cur_ld     = 1'b0;
    nxt_ld     = 1'b0;
    if (promote) begin
      cur_v_n    = nxt_v;
      cur_tag_n  = nxt_tag;
      cur_line_n = nxt_line;
      nxt_v_n    = 1'b0;
      cur_ld     = 1'b1;
    end
    if (fill_en) begin
      if (fill_kind == RD_DEMAND) begin
        cur_v_n    = 1'b1;
        cur_tag_n  = fill_tag;
        cur_line_n = fill_line;
        nxt_v_n    = 1'b0;
        cur_ld     = 1'b1;
      end else begin
        nxt_v_n    = 1'b1;
        nxt_tag_n  = fill_tag;
        nxt_line_n = fill_line;
        nxt_ld     = 1'b1;
      end
    end
    if (clr) begin
      cur_v_n = 1'b0;
      nxt_v_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_v <= 1'b0;
      nxt_v <= 1'b0;
    end else begin
      cur_v <= cur_v_n;
      nxt_v <= nxt_v_n;
    end
  end

  always_ff @(posedge clk) begin
    if (cur_ld) begin
      cur_tag  <= cur_tag_n;
      cur_line <= cur_line_n;
    end
    if (nxt_ld) begin
      nxt_tag  <= nxt_tag_n;
      nxt_line <= nxt_line_n;
    end
  end
endmodule

// File: rtl/flp_read_engine.sv
module flp_read_engine
  import flp_pkg::*;
#(
  parameter int TAG_W = 28,
  parameter int WS_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cancel,
  input  logic             start,
  input  rd_kind_e         start_kind,
  input  logic [TAG_W-1:0] start_tag,
  input  logic [WS_W-1:0]  wait_cfg,
  output logic             busy_o,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic             done,
  output rd_kind_e         done_kind,
  output logic             arr_en,
  output logic [TAG_W-1:0] arr_addr
);
  logic             busy, busy_n;
  logic [WS_W-1:0]  cnt, cnt_n, cnt_now;
  logic [TAG_W-1:0] rd_tag, tag_now;
  rd_kind_e         rd_kind, kind_now;
  logic             active, ld;

  // A start launches the read in its own cycle; a start while busy restarts.
  assign active   = start | busy;
  assign cnt_now  = start ? wait_cfg   : cnt;
  assign tag_now  = start ? start_tag  : rd_tag;
  assign kind_now = start ? start_kind : rd_kind;

  assign arr_en    = active & ~cancel;
  assign arr_addr  = tag_now;
  assign done      = arr_en & (cnt_now == '0);
  assign done_kind = kind_now;
  assign busy_o    = busy;
  assign rd_tag_o  = rd_tag;
  assign ld        = arr_en;

  always_comb begin
    busy_n = busy;
    cnt_n  = cnt;
    if (cancel) begin
      busy_n = 1'b0;
    end else if (active) begin
      busy_n = (cnt_now != '0);
      cnt_n  = cnt_now - WS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= busy_n;
  end

  always_ff @(posedge clk) begin
    if (ld) begin
      cnt     <= cnt_n;
      rd_tag  <= tag_now;
      rd_kind <= kind_now;
    end
  end
endmodule

// File: rtl/flp_fetch_ctrl.sv
module flp_fetch_ctrl
  import flp_pkg::*;
#(
  parameter int TAG_W = 28,
  parameter int WPL   = 4,
  localparam int SEL_W = $clog2(WPL)
) (
  input  logic             fetch_req,
  input  logic [TAG_W-1:0] fetch_tag,
  input  logic [SEL_W-1:0] fetch_sel,
  input  logic             inval,
  input  logic             hit_cur,
  input  logic             hit_nxt,
  input  logic             cur_v,
  input  logic [TAG_W-1:0] cur_tag,
  input  logic             nxt_v,
  input  logic [TAG_W-1:0] nxt_tag,
  input  logic             eng_busy,
  input  logic [TAG_W-1:0] eng_tag,
  output logic             ready,
  output logic             promote,
  output logic             start,
  output rd_kind_e         start_kind,
  output logic [TAG_W-1:0] start_tag
);
  logic last_word, pending_same, demand_go, ahead_go;

  assign last_word    = (fetch_sel == SEL_W'(WPL - 1));
  assign ready        = fetch_req & ~inval & (hit_cur | hit_nxt);
  assign promote      = ready & ((hit_cur & last_word & nxt_v) | (hit_nxt & ~hit_cur));
  assign pending_same = eng_busy & (eng_tag == fetch_tag);
  assign demand_go    = fetch_req & ~inval & ~hit_cur & ~hit_nxt & ~pending_same;
  assign ahead_go     = ~inval & ~demand_go & ~eng_busy & (promote | (cur_v & ~nxt_v));

  always_comb begin
    start      = demand_go | ahead_go;
    start_kind = demand_go ? RD_DEMAND : RD_AHEAD;
    if (demand_go)    start_tag = fetch_tag;
    else if (promote) start_tag = nxt_tag + TAG_W'(1);
    else              start_tag = cur_tag + TAG_W'(1);
  end
endmodule

// File: rtl/flash_line_prefetch.sv
module flash_line_prefetch
  import flp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int WS_W       = 3,
  localparam int SEL_W  = $clog2(LINE_WORDS),
  localparam int OFS_W  = SEL_W + $clog2(WORD_W / 8),
  localparam int TAG_W  = ADDR_W - OFS_W,
  localparam int LINE_W = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [WS_W-1:0]   wait_cfg,
  input  logic              inval,
  output logic              fetch_ready,
  output logic [WORD_W-1:0] fetch_rdata,
  output logic              arr_en,
  output logic [TAG_W-1:0]  arr_addr,
  input  logic [LINE_W-1:0] arr_rdata
);
  logic [TAG_W-1:0]  fetch_tag, cur_tag, nxt_tag, eng_tag, start_tag;
  logic [SEL_W-1:0]  fetch_sel;
  logic              hit_cur, hit_nxt, cur_v, nxt_v, eng_busy;
  logic              ready, promote, start, done;
  rd_kind_e          start_kind, done_kind;
  logic [WORD_W-1:0] sel_word;

  assign fetch_tag = fetch_addr[ADDR_W-1:OFS_W];
  assign fetch_sel = fetch_addr[OFS_W-1:OFS_W-SEL_W];

  flp_fetch_ctrl #(.TAG_W(TAG_W), .WPL(LINE_WORDS)) u_ctrl (
    .fetch_req (fetch_req),  .fetch_tag (fetch_tag), .fetch_sel (fetch_sel),
    .inval     (inval),      .hit_cur   (hit_cur),   .hit_nxt   (hit_nxt),
    .cur_v     (cur_v),      .cur_tag   (cur_tag),   .nxt_v     (nxt_v),
    .nxt_tag   (nxt_tag),    .eng_busy  (eng_busy),  .eng_tag   (eng_tag),
    .ready     (ready),      .promote   (promote),   .start     (start),
    .start_kind(start_kind), .start_tag (start_tag)
  );

  flp_read_engine #(.TAG_W(TAG_W), .WS_W(WS_W)) u_eng (
    .clk       (clk),        .rst_n     (rst_n),     .cancel    (inval),
    .start     (start),      .start_kind(start_kind), .start_tag(start_tag),
    .wait_cfg  (wait_cfg),   .busy_o    (eng_busy),  .rd_tag_o  (eng_tag),
    .done      (done),       .done_kind (done_kind), .arr_en    (arr_en),
    .arr_addr  (arr_addr)
  );

  flp_line_store #(.TAG_W(TAG_W), .WORD_W(WORD_W), .WPL(LINE_WORDS)) u_store (
    .clk      (clk),       .rst_n    (rst_n),     .clr      (inval),
    .fetch_tag(fetch_tag), .fetch_sel(fetch_sel), .promote  (promote),
    .fill_en  (done),      .fill_kind(done_kind), .fill_tag (arr_addr),
    .fill_line(arr_rdata), .hit_cur  (hit_cur),   .hit_nxt  (hit_nxt),
    .sel_word (sel_word),  .cur_tag_o(cur_tag),   .cur_v_o  (cur_v),
    .nxt_tag_o(nxt_tag),   .nxt_v_o  (nxt_v)
  );

  assign fetch_ready = ready;
  assign fetch_rdata = ready ? sel_word : '0;
endmodule

// File: rtl/flash_line_prefetch_chk.sv
module flash_line_prefetch_chk #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WS_W   = 3,
  localparam int STALL_MAX = 2 * (1 << WS_W) + 2,
  localparam int CNT_W     = $clog2(STALL_MAX + 2)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_req,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              inval,
  input logic              fetch_ready,
  input logic [WORD_W-1:0] fetch_rdata,
  input logic              arr_en
);
  logic [CNT_W-1:0]  stall_cnt;
  logic [ADDR_W-1:0] prev_addr;
  logic              stalling;

  assign stalling = fetch_req & ~fetch_ready & ~inval;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_cnt <= '0;
      prev_addr <= '0;
    end else begin
      prev_addr <= fetch_addr;
      if (!stalling || (stall_cnt != '0 && fetch_addr != prev_addr)) stall_cnt <= '0;
      else if (stall_cnt <= CNT_W'(STALL_MAX)) stall_cnt <= stall_cnt + CNT_W'(1);
    end
  end

  // R2: a delivered word needs a live request and no invalidate
  p_ready_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |-> (fetch_req && !inval));
  // R3: a held miss keeps the array busy
  p_miss_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !inval && !fetch_ready) |-> arr_en);
  // R3: a held stall is bounded
  p_stall_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stall_cnt <= CNT_W'(STALL_MAX));
  // R9: invalidate blocks the array and the following delivery
  p_inval_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inval |-> !arr_en);
  p_after_inval_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inval |=> !fetch_ready);
  // R10: data is zero while stalled or idle
  p_rdata_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_ready |-> (fetch_rdata == '0));
endmodule

bind flash_line_prefetch flash_line_prefetch_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WS_W(WS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
  .inval(inval), .fetch_ready(fetch_ready), .fetch_rdata(fetch_rdata),
  .arr_en(arr_en)
);

// File: tb/sim_flash_line_prefetch.sv
module sim_flash_line_prefetch;
  logic         clk, rst_n, fetch_req, inval, fetch_ready, arr_en;
  logic [31:0]  fetch_addr, fetch_rdata, salt;
  logic [2:0]   wait_cfg;
  logic [27:0]  arr_addr;
  logic [127:0] arr_rdata;
  int n_chk, n_fail;

  flash_line_prefetch u0 (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .wait_cfg(wait_cfg), .inval(inval), .fetch_ready(fetch_ready),
    .fetch_rdata(fetch_rdata), .arr_en(arr_en), .arr_addr(arr_addr),
    .arr_rdata(arr_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Array model: each word holds its own byte address xor salt
  always_comb begin
    for (int k = 0; k < 4; k++)
      arr_rdata[k*32 +: 32] = {arr_addr, 2'(k), 2'b00} ^ salt;
  end

  function automatic logic [31:0] exp_word(input logic [31:0] a, input logic [31:0] s);
    return {a[31:2], 2'b00} ^ s;
  endfunction

  // {wait, address, expected stall cycles}
  localparam logic [38:0] VEC [12] = '{
    {3'd2, 32'h0000_1000, 4'd3}, {3'd2, 32'h0000_1004, 4'd0},
    {3'd2, 32'h0000_1008, 4'd0}, {3'd2, 32'h0000_100C, 4'd0},
    {3'd2, 32'h0000_1010, 4'd0}, {3'd2, 32'h0000_1014, 4'd0},
    {3'd2, 32'h0000_2000, 4'd3}, {3'd2, 32'h0000_2004, 4'd0},
    {3'd2, 32'h0000_2008, 4'd0}, {3'd2, 32'h0000_200C, 4'd0},
    {3'd2, 32'h0000_2010, 4'd0}, {3'd2, 32'h0000_1018, 4'd3}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fetch(input logic [31:0] a, output logic [31:0] d, output int st,
                       output logic [27:0] a0, output logic e0, output bit zq);
    st = 0;
    zq = 1'b1;
    @(negedge clk);
    fetch_req  = 1'b1;
    fetch_addr = a;
    #2;
    a0 = arr_addr;
    e0 = arr_en;
    while (!fetch_ready && st < 64) begin
      if (fetch_rdata != '0) zq = 1'b0;
      st++;
      @(negedge clk);
      #2;
    end
    d = fetch_rdata;
  endtask

  task automatic do_inval();
    @(negedge clk);
    fetch_req = 1'b0;
    inval     = 1'b1;
    @(negedge clk);
    inval     = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R3: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [27:0] a0;
    logic        e0;
    bit          zq;
    int          st;
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    fetch_req = 1'b0;
    fetch_addr = '0;
    inval = 1'b0;
    wait_cfg = 3'd0;
    salt = 32'hC3A5_0000;

    // R1: reset state
    repeat (3) @(negedge clk);
    #2;
    check(!fetch_ready && !arr_en, "R1", "outputs in reset", {arr_en, fetch_ready}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(!fetch_ready && !arr_en, "R1", "idle after reset", {arr_en, fetch_ready}, 0);

    // Vector table: mixed sequential and jumping fetches at wait 2
    for (int i = 0; i < 12; i++) begin
      wait_cfg = VEC[i][38:36];
      fetch(VEC[i][35:4], d, st, a0, e0, zq);
      check(st == int'(VEC[i][3:0]), (VEC[i][3:0] != 0) ? "R3" : "R5", "vector stall",
            st, VEC[i][3:0]);
      check(d == exp_word(VEC[i][35:4], salt), "R2", "vector data", d, exp_word(VEC[i][35:4], salt));
    end

    // R5/R6: streams across many lines for waits 0..3
    for (int w = 0; w < 4; w++) begin
      int tot;
      int bad;
      logic [31:0] base;
      wait_cfg = 3'(w);
      do_inval();
      base = 32'h0001_0000 + 32'(w) * 32'h1000;
      tot = 0;
      bad = 0;
      for (int j = 0; j < 24; j++) begin
        fetch(base + 32'(4 * j), d, st, a0, e0, zq);
        if (j == 0) begin
          check(st == w + 1, "R3", "first miss stall", st, w + 1);
          check(e0 && a0 == base[31:4], "R3", "demand line", {4'd0, a0}, {4'd0, base[31:4]});
        end else tot += st;
        if (d != exp_word(base + 32'(4 * j), salt)) bad++;
      end
      check(tot == 0, "R5", "stream stall total", tot, 0);
      check(bad == 0, "R6", "stream data across promotions", bad, 0);
    end

    // R4: read-ahead starts without a miss
    wait_cfg = 3'd3;
    do_inval();
    fetch(32'h0000_4000, d, st, a0, e0, zq);
    check(st == 4, "R3", "miss stall wait 3", st, 4);
    check(arr_en && arr_addr == 28'h000_0401, "R4", "read-ahead line", {4'd0, arr_addr}, 32'h401);

    // R7: jump cancels read-ahead
    fetch(32'h0000_8000, d, st, a0, e0, zq);
    check(st == 4, "R7", "stall after cancel", st, 4);
    check(e0 && a0 == 28'h000_0800, "R7", "demand replaces read-ahead", {4'd0, a0}, 32'h800);
    check(d == exp_word(32'h0000_8000, salt), "R7", "data after cancel", d, exp_word(32'h0000_8000, salt));
    check(zq, "R10", "rdata zero while stalled", {31'd0, zq}, 1);

    // R8: miss on the line in flight waits for it; R6: promotion starts next read
    do_inval();
    fetch(32'h0000_5000, d, st, a0, e0, zq);
    fetch(32'h0000_5010, d, st, a0, e0, zq);
    check(st == 3, "R8", "wait for read in flight", st, 3);
    check(d == exp_word(32'h0000_5010, salt), "R8", "data of awaited line", d, exp_word(32'h0000_5010, salt));
    check(arr_en && arr_addr == 28'h000_0502, "R6", "read after promotion", {4'd0, arr_addr}, 32'h502);

    // R9: stale data until invalidate, then fresh
    wait_cfg = 3'd1;
    do_inval();
    fetch(32'h0000_6000, d, st, a0, e0, zq);
    check(st == 2, "R3", "miss stall wait 1", st, 2);
    fetch(32'h0000_6004, d, st, a0, e0, zq);
    salt = 32'h1234_0000;
    fetch(32'h0000_6008, d, st, a0, e0, zq);
    check(st == 0 && d == exp_word(32'h0000_6008, 32'hC3A5_0000), "R9", "held contents kept",
          d, exp_word(32'h0000_6008, 32'hC3A5_0000));
    @(negedge clk);
    inval = 1'b1;
    fetch_req = 1'b1;
    fetch_addr = 32'h0000_6008;
    #2;
    check(!fetch_ready && !arr_en, "R9", "quiet during invalidate", {arr_en, fetch_ready}, 0);
    @(negedge clk);
    inval = 1'b0;
    fetch_req = 1'b0;
    fetch(32'h0000_6008, d, st, a0, e0, zq);
    check(st == 2, "R9", "miss after invalidate", st, 2);
    check(d == exp_word(32'h0000_6008, salt), "R9", "fresh contents", d, exp_word(32'h0000_6008, salt));

    @(negedge clk);
    fetch_req = 1'b0;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule